// File: doc/BRIEF.md
# Memory-Mapped PCI Configuration Address Decoder

This block sits in a host bridge between the CPU bus and the PCI configuration port. A 4 MiB memory window turns CPU loads and stores into configuration cycles. Inside the window, one of eleven address bits picks the target device, one-hot style. The block turns that bit's position into a device number. It then passes the downstream port a flat configuration address, made of the device number and an 11-bit register offset, along with byte enables taken from the access size. Data lanes are little-endian and pass through without swapping.

One fixed byte address is decoded as an interrupt-acknowledge location. A one-byte read there asks the external interrupt controller for its vector and returns that vector. The block also folds the slots' interrupt pins onto a small set of interrupt lines, using a parity swizzle of pin index and device number. The CPU holds a request until the block answers with a one-cycle ready. An address that neither range decodes is left unclaimed and flagged, so another target on the bus can take it.

Top module: `pcicfg_mmio_decoder`

## Requirements
- R1: Only addresses from 0x8080_0000 up to 0x80BF_FFFF start a configuration cycle. A request at any address outside this window, other than the interrupt-acknowledge address, raises `cpu_nsel` in the same cycle, issues no `cfg_valid` and never raises `cpu_ready`.
- R2: Bits [10:0] of `cfg_addr` equal bits [10:0] of the CPU address.
- R3: Bits [15:11] of `cfg_addr` hold the index (0 to 10) of the lowest set bit among CPU address bits 11 to 21. The lowest set bit wins over any higher ones.
- R4: When none of CPU address bits 11 to 21 is set, bits [15:11] of `cfg_addr` equal 11.
- R5: `cpu_size` is coded 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. `cfg_be` is 1 shifted left by addr[1:0] for 1 byte, 3 shifted left by {addr[1],0} for 2 bytes, and 4'b1111 for 4 bytes. Write data passes to `cfg_wdata` with no lane swap, and read data passes back to `cpu_rdata` with no lane swap.
- R6: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid`, `cfg_addr`, `cfg_be`, `cfg_we` and `cfg_wdata` stay unchanged in the next cycle.
- R7: `cpu_ready` is a single-cycle pulse. A configuration write completes in the cycle after the `cfg_valid`/`cfg_ready` handshake. A configuration read completes in the cycle after `cfg_rvalid`, and returns the `cfg_rdata` captured with it.
- R8: A one-byte read at 0xBFFF_FFF0 raises `iack_req` for exactly one cycle. `cpu_ready` follows in the next cycle, with `cpu_rdata` = {24'h0, `iack_vec`}.
- R9: A read wider than one byte at 0xBFFF_FFF0, or any write there, completes without raising `iack_req` or `cfg_valid`. Such a read returns 32'hFFFF_FFFF.
- R10: Slot s has device number s+1, and its pin p (bit s*4+p of `slot_int`) drives line (p + s + 1) & 1 of `irq_out`. A line is high, one cycle later, when any pin routed to it is high.
- R11: Lines 2 and 3 of `irq_out` stay low for every pattern of `slot_int`.
- R12: After reset, `cpu_ready`, `cfg_valid`, `iack_req` and `irq_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size code (0 = 1 B, 1 = 2 B, 2/3 = 4 B) |
| cpu_wdata | input | 32 | Write data in little-endian lane positions |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_nsel | output | 1 | Request not claimed by this block |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Downstream accepts the request |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 16 | {device[4:0], offset[10:0]} |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rvalid | input | 1 | Read response valid |
| cfg_rdata | input | 32 | Read response data |
| iack_req | output | 1 | Interrupt-acknowledge strobe to the controller |
| iack_vec | input | 8 | Vector from the interrupt controller |
| slot_int | input | 16 | Slot interrupt pin levels, four per slot |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
The bench uses the default parameters. These give a window based at 0x8080_0000 with a 22-bit span, so the select field covers eleven bits, including the all-clear case that yields device 11 and the all-set top address that yields device 0. Four slots with device numbers 1 to 4 cover both parities of the swizzle, which is what shows that lines 2 and 3 never rise. The 32-bit data path brings every byte-enable shape within reach, as well as the wide-versus-byte distinction at the interrupt-acknowledge address.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_RWAIT = 3'd2,
    ST_IACK  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/pcicfg_addr_map.sv
module pcicfg_addr_map #(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_BITS = 22,
  parameter int OFS_BITS = 11,
  parameter int CFG_AW = 16,
  parameter logic [AW-1:0] IACK_ADDR = 32'hBFFF_FFF0,
  localparam int NSEL = WIN_BITS - OFS_BITS,
  localparam int DEV_W = CFG_AW - OFS_BITS
) (
  input  logic [AW-1:0]     addr,
  output logic              hit_cfg,
  output logic              hit_iack,
  output logic [CFG_AW-1:0] flat_addr
);

  logic [DEV_W-1:0] dev_num;

  // window compare on the bits above the window span
  assign hit_cfg  = (addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
  assign hit_iack = (addr == IACK_ADDR);

  // lowest set select bit wins; none set gives NSEL
  always_comb begin
    dev_num = DEV_W'(NSEL);
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (addr[OFS_BITS + i]) dev_num = DEV_W'(i);
    end
  end

  assign flat_addr = {dev_num, addr[OFS_BITS-1:0]};

  always_comb begin
    if (hit_cfg) assert (!hit_iack) else $error("p_ranges_disjoint_r1");
  end

endmodule

// File: rtl/pcicfg_be_gen.sv
module pcicfg_be_gen #(
  parameter int DW = 32,
  localparam int BE_W = DW / 8,
  localparam int LB = $clog2(BE_W)
) (
  input  logic [1:0]      size,
  input  logic [LB-1:0]   addr_lo,
  output logic [BE_W-1:0] be
);
  import pcicfg_pkg::*;

  logic [LB-1:0] half_lo;

  assign half_lo = {addr_lo[LB-1:1], 1'b0};

  always_comb begin
    unique case (size)
      SZ_BYTE: be = BE_W'(1) << addr_lo;
      SZ_HALF: be = BE_W'(3) << half_lo;
      default: be = '1;
    endcase
  end

endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq #(
  parameter int DW = 32,
  parameter int CFG_AW = 16,
  parameter int VEC_W = 8,
  localparam int BE_W = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [1:0]        cpu_size,
  input  logic              hit_cfg,
  input  logic              hit_iack,
  input  logic [CFG_AW-1:0] flat_addr,
  input  logic [BE_W-1:0]   be_in,
  output logic              cpu_ready,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [BE_W-1:0]   cfg_be,
  output logic [DW-1:0]     cfg_wdata,
  input  logic              cfg_rvalid,
  input  logic [DW-1:0]     cfg_rdata,
  output logic              iack_req,
  input  logic [VEC_W-1:0]  iack_vec
);
  import pcicfg_pkg::*;

  seq_state_t state_q, state_d;
  logic [DW-1:0] rdata_q;
  logic          iack_byte_rd;

  assign iack_byte_rd = hit_iack && !cpu_we && (cpu_size == SZ_BYTE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && hit_cfg)        state_d = ST_ISSUE;
        else if (cpu_req && iack_byte_rd) state_d = ST_IACK;
        else if (cpu_req && hit_iack)  state_d = ST_DONE;
      end
      ST_ISSUE: if (cfg_ready) state_d = cfg_we ? ST_DONE : ST_RWAIT;
      ST_RWAIT: if (cfg_rvalid) state_d = ST_DONE;
      ST_IACK:  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // request fields latched once per access
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else if (state_q == ST_IDLE && cpu_req && hit_cfg) begin
      cfg_we    <= cpu_we;
      cfg_addr  <= flat_addr;
      cfg_be    <= be_in;
      cfg_wdata <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (cpu_req && hit_iack && !iack_byte_rd) rdata_q <= '1;
        ST_RWAIT: if (cfg_rvalid) rdata_q <= cfg_rdata;
        ST_IACK:  rdata_q <= DW'(iack_vec);
        default:  ;
      endcase
    end
  end

  assign cfg_valid = (state_q == ST_ISSUE);
  assign iack_req  = (state_q == ST_IACK);
  assign cpu_ready = (state_q == ST_DONE);
  assign cpu_rdata = rdata_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) &&
      $stable(cfg_be) && $stable(cfg_we) && $stable(cfg_wdata)));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_write_done_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready && cfg_we) |=> cpu_ready);

  p_iack_once_r8: assert property (@(posedge clk) disable iff (rst)
    iack_req |=> (!iack_req && cpu_ready));

endmodule

// File: rtl/pcicfg_irq_swz.sv
module pcicfg_irq_swz #(
  parameter int NUM_SLOTS = 4,
  parameter int PINS = 4,
  parameter int SLOT_DEV0 = 1,
  parameter int NUM_LINES = 4,
  localparam int NIN = NUM_SLOTS * PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NIN-1:0]       slot_int,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [NUM_LINES-1:0] lines_d;

  always_comb begin
    lines_d = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS; p++) begin
        if (slot_int[s*PINS + p]) lines_d[(p + SLOT_DEV0 + s) % 2] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= lines_d;
  end

  p_any_raises_r10: assert property (@(posedge clk) disable iff (rst)
    (|slot_int) |=> (|irq_out));

  p_none_clears_r10: assert property (@(posedge clk) disable iff (rst)
    !(|slot_int) |=> !(|irq_out));

endmodule

// File: rtl/pcicfg_mmio_decoder.sv
module pcicfg_mmio_decoder #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_BITS = 22,
  parameter int OFS_BITS = 11,
  parameter int CFG_AW = 16,
  parameter logic [AW-1:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter int VEC_W = 8,
  parameter int NUM_SLOTS = 4,
  parameter int PINS = 4,
  parameter int SLOT_DEV0 = 1,
  parameter int NUM_LINES = 4,
  localparam int BE_W = DW / 8,
  localparam int LB = $clog2(BE_W),
  localparam int NIN = NUM_SLOTS * PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [AW-1:0]        cpu_addr,
  input  logic [1:0]           cpu_size,
  input  logic [DW-1:0]        cpu_wdata,
  output logic                 cpu_ready,
  output logic [DW-1:0]        cpu_rdata,
  output logic                 cpu_nsel,
  output logic                 cfg_valid,
  input  logic                 cfg_ready,
  output logic                 cfg_we,
  output logic [CFG_AW-1:0]    cfg_addr,
  output logic [BE_W-1:0]      cfg_be,
  output logic [DW-1:0]        cfg_wdata,
  input  logic                 cfg_rvalid,
  input  logic [DW-1:0]        cfg_rdata,
  output logic                 iack_req,
  input  logic [VEC_W-1:0]     iack_vec,
  input  logic [NIN-1:0]       slot_int,
  output logic [NUM_LINES-1:0] irq_out
);

  logic              hit_cfg, hit_iack;
  logic [CFG_AW-1:0] flat_addr;
  logic [BE_W-1:0]   be_w;

  pcicfg_addr_map #(
    .AW(AW), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS), .OFS_BITS(OFS_BITS),
    .CFG_AW(CFG_AW), .IACK_ADDR(IACK_ADDR)
  ) u_map (
    .addr(cpu_addr), .hit_cfg(hit_cfg), .hit_iack(hit_iack), .flat_addr(flat_addr)
  );

  pcicfg_be_gen #(.DW(DW)) u_be (
    .size(cpu_size), .addr_lo(cpu_addr[LB-1:0]), .be(be_w)
  );

  pcicfg_seq #(.DW(DW), .CFG_AW(CFG_AW), .VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_size(cpu_size),
    .hit_cfg(hit_cfg), .hit_iack(hit_iack), .flat_addr(flat_addr), .be_in(be_w),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .iack_req(iack_req), .iack_vec(iack_vec)
  );

  pcicfg_irq_swz #(
    .NUM_SLOTS(NUM_SLOTS), .PINS(PINS), .SLOT_DEV0(SLOT_DEV0), .NUM_LINES(NUM_LINES)
  ) u_swz (
    .clk(clk), .rst(rst), .slot_int(slot_int), .irq_out(irq_out)
  );

  assign cpu_nsel = cpu_req && !hit_cfg && !hit_iack;

  p_nsel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_nsel |-> (!cfg_valid && !cpu_ready && !iack_req));

endmodule

// File: tb/sim_pcicfg_mmio_decoder.sv
module sim_pcicfg_mmio_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_nsel;
  logic [31:0] cpu_rdata;
  logic        cfg_valid, cfg_we;
  logic        cfg_ready = 1'b0, cfg_rvalid = 1'b0;
  logic [15:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        iack_req;
  logic [7:0]  iack_vec = '0;
  logic [15:0] slot_int = '0;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcicfg_mmio_decoder u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_dev(input logic [31:0] a);
    for (int i = 0; i < 11; i++) if (a[11+i]) return 5'(i);
    return 5'd11;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  // one configuration access; stall = cycles cfg_ready is held low
  task automatic cfg_access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                            input logic [31:0] wd, input logic [31:0] rd, input int stall);
    logic [15:0] exp_addr;
    int n;
    exp_addr = {exp_dev(a), a[10:0]};
    @(negedge clk);
    cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd; cpu_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cfg_valid && n < 10);
    check(cfg_valid, "R1 cfg_valid in window", 32'(cfg_valid), 32'd1);
    check(cfg_addr[10:0] == exp_addr[10:0], "R2 offset", 32'(cfg_addr[10:0]), 32'(exp_addr[10:0]));
    check(cfg_addr[15:11] == exp_addr[15:11], (exp_addr[15:11] == 5'd11) ? "R4 device none set" : "R3 device",
          32'(cfg_addr[15:11]), 32'(exp_addr[15:11]));
    check(cfg_be == exp_be(sz, a[1:0]), "R5 byte enables", 32'(cfg_be), 32'(exp_be(sz, a[1:0])));
    check(cfg_we == we, "R5 direction", 32'(cfg_we), 32'(we));
    if (we) check(cfg_wdata == wd, "R5 write lanes", cfg_wdata, wd);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(cfg_valid && cfg_addr == exp_addr && cfg_be == exp_be(sz, a[1:0]),
            "R6 held while stalled", {15'd0, cfg_valid, cfg_addr}, {15'd0, 1'b1, exp_addr});
    end
    cfg_ready = 1'b1;
    @(negedge clk);
    cfg_ready = 1'b0;
    if (!we) begin
      check(!cpu_ready, "R7 no early ready", 32'(cpu_ready), 32'd0);
      cfg_rvalid = 1'b1; cfg_rdata = rd;
      @(negedge clk);
      cfg_rvalid = 1'b0; cfg_rdata = '0;
    end
    check(cpu_ready, "R7 ready timing", 32'(cpu_ready), 32'd1);
    if (!we) check(cpu_rdata == rd, "R5 read lanes", cpu_rdata, rd);
    cpu_req = 1'b0;
    @(negedge clk);
    check(!cpu_ready, "R7 ready single pulse", 32'(cpu_ready), 32'd0);
  endtask

  task automatic miss_access(input logic [31:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_size = 2'd2; cpu_we = 1'b0; cpu_req = 1'b1;
    #1;
    check(cpu_nsel, "R1 nsel outside window", 32'(cpu_nsel), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cfg_valid && !cpu_ready && !iack_req, "R1 unclaimed stays quiet",
            {29'd0, cfg_valid, cpu_ready, iack_req}, 32'd0);
    end
    cpu_req = 1'b0;
  endtask

  task automatic iack_access(input logic [1:0] sz, input logic we, input logic [7:0] vec);
    int seen;
    iack_vec = vec;
    @(negedge clk);
    cpu_addr = 32'hBFFF_FFF0; cpu_size = sz; cpu_we = we; cpu_req = 1'b1;
    #1;
    check(!cpu_nsel, "R8 iack address claimed", 32'(cpu_nsel), 32'd0);
    seen = 0;
    @(negedge clk);
    if (iack_req) begin
      seen++;
      @(negedge clk);
    end
    check(!cfg_valid, "R9 no config cycle at iack", 32'(cfg_valid), 32'd0);
    check(cpu_ready, "R8 iack completes", 32'(cpu_ready), 32'd1);
    if (sz == 2'd0 && !we) begin
      check(seen == 1, "R8 iack_req one cycle", 32'(seen), 32'd1);
      check(cpu_rdata == {24'd0, vec}, "R8 vector returned", cpu_rdata, {24'd0, vec});
    end else begin
      check(seen == 0, "R9 no iack_req", 32'(seen), 32'd0);
      if (!we) check(cpu_rdata == 32'hFFFF_FFFF, "R9 wide read all ones", cpu_rdata, 32'hFFFF_FFFF);
    end
    cpu_req = 1'b0;
    @(negedge clk);
    check(!iack_req && !cpu_ready, "R8 iack idle after", {30'd0, iack_req, cpu_ready}, 32'd0);
  endtask

  function automatic logic [3:0] exp_irq(input logic [15:0] pins);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        if (pins[s*4+p]) r[(p + s + 1) % 2] = 1'b1;
    return r;
  endfunction

  task automatic irq_case(input logic [15:0] pins);
    @(negedge clk);
    slot_int = pins;
    @(negedge clk);
    check(irq_out == exp_irq(pins), "R10 swizzle", 32'(irq_out), 32'(exp_irq(pins)));
    check(irq_out[3:2] == 2'b00, "R11 upper lines low", 32'(irq_out[3:2]), 32'd0);
  endtask

  task automatic reset_check();
    repeat (4) @(negedge clk);
    check(!cpu_ready && !cfg_valid && !iack_req && irq_out == 4'd0, "R12 reset state",
          {25'd0, cpu_ready, cfg_valid, iack_req, irq_out}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !cfg_valid, "R12 idle after reset", {30'd0, cpu_ready, cfg_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    reset_check();
    // R3 each select bit alone
    for (int k = 0; k < 11; k++)
      cfg_access(32'h8080_0000 | (32'd1 << (11 + k)) | 32'h24, 2'd2, 1'b0, 32'hA5A5_0000 + k, 32'h1000 + k, 0);
    // R3 lowest of several wins
    cfg_access(32'h8080_8804, 2'd2, 1'b1, 32'h1234_5678, '0, 2);
    // R4 none set
    cfg_access(32'h8080_0010, 2'd2, 1'b0, '0, 32'hCAFE_F00D, 1);
    // top of window, all select bits set
    cfg_access(32'h80BF_FFFC, 2'd2, 1'b0, '0, 32'h0BAD_BEEF, 0);
    // R5 byte-enable shapes
    cfg_access(32'h8081_0003, 2'd0, 1'b1, 32'hDD00_0000, '0, 0);
    cfg_access(32'h8082_0002, 2'd1, 1'b1, 32'hBEEF_0000, '0, 3);
    cfg_access(32'h8084_0001, 2'd1, 1'b0, '0, 32'h0000_5566, 0);
    cfg_access(32'h8088_0000, 2'd3, 1'b1, 32'h0102_0304, '0, 0);
    // R1 outside
    miss_access(32'h80C0_0000);
    miss_access(32'h807F_FFFC);
    miss_access(32'h0000_0CF8);
    miss_access(32'hBFFF_FFF4);
    // R8 / R9
    iack_access(2'd0, 1'b0, 8'h2B);
    iack_access(2'd0, 1'b0, 8'hF0);
    iack_access(2'd2, 1'b0, 8'h11);
    iack_access(2'd1, 1'b0, 8'h11);
    iack_access(2'd0, 1'b1, 8'h11);
    // R10 / R11
    irq_case(16'h0001);
    irq_case(16'h0010);
    irq_case(16'h0022);
    irq_case(16'h0004);
    irq_case(16'hFFFF);
    irq_case(16'h0000);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule